// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns two encoder lines, A and B, into a position value. Both lines are first brought into the block's clock domain. A decoder then turns each sampled change into at most one count step per clock, with a direction. The count source is chosen from four modes:

- x4 quadrature, where every edge of either line counts;
- pulse plus direction, where A rising edges count and the level of B picks the direction;
- up-only, where only A counts;
- down-only, where only A counts.

In the up-only and down-only modes, a flag selects whether both edges of A count or only its rising edges.

The count runs between zero and a programmable maximum and wraps at either end. Software reaches the block through a flat register port. Writes take effect on a clock edge, and reads are combinational from the address. A software load of the count is refused when the value lies above the maximum. An enable flag freezes counting without blocking software loads.

Top module: `qep_position_counter`

## Requirements
- R1: After reset the count reads 0, the maximum reads 0xFFFF_FFFF, and the decoder and main control registers read 0.
- R2: In source mode 00, the two-bit state {A,B} counts up on the step sequence 00→01→11→10→00 and counts down on the reverse sequence.
- R3: In mode 00, a change in which A and B both flip in the same sample produces no count.
- R4: In mode 01, only a rising edge of A counts. It counts up when B is 1 and down when B is 0. Edges of B and falling edges of A never count.
- R5: In mode 10, B is ignored. With decoder bit 11 at 0 only A rising edges add one, and with bit 11 at 1 both A edges add one.
- R6: In mode 11, B is ignored. With decoder bit 11 at 0 only A rising edges subtract one, and with bit 11 at 1 both A edges subtract one.
- R7: While main control bit 3 is 0, the count keeps its value whatever A and B do. Software loads still apply.
- R8: An up step at or above the maximum gives 0. A down step at 0 gives the maximum.
- R9: A write to offset 0x00 with a value no greater than the maximum loads the count on the next edge. A larger value leaves the count unchanged.
- R10: The byte offsets are: count at 0x00, maximum at 0x08, decoder control at 0x28, main control at 0x2A. Only decoder bits 15:14 (source) and 11 (edge mode) and main control bit 3 (enable) hold data. Other bits and other offsets read 0.
- R11: A change on an input moves the count on the third rising clock edge after it is applied, never earlier. Without a load, the count changes by at most one step per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | 1 | Encoder line A, asynchronous |
| enc_b_i | input | 1 | Encoder line B, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte offset |
| wdata_i | input | 32 | Write data (low 16 bits for 16-bit registers) |
| rdata_o | output | 32 | Read data for addr_i |

## Verification
The bound checker watches the following on every cycle:
- the count freezes when disabled;
- an accepted load lands exactly, and a refused load leaves the count alone;
- simultaneous double flips in quadrature mode are not counted;
- B-only activity in pulse mode is not counted;
- the count never moves by more than one step per clock outside a load.

Only the bench scenarios show the following:
- the direction chosen in each mode;
- the effect of the edge-mode flag;
- the wrap values at both ends;
- the exact three-edge latency;
- the register layout read back through the port.

// File: rtl/qep_pkg.sv
package qep_pkg;
  typedef enum logic [1:0] {
    SRC_QUAD = 2'b00,
    SRC_PDIR = 2'b01,
    SRC_UP   = 2'b10,
    SRC_DOWN = 2'b11
  } src_e;

  localparam logic [5:0] OFF_POS = 6'h00;
  localparam logic [5:0] OFF_MAX = 6'h08;
  localparam logic [5:0] OFF_DEC = 6'h28;
  localparam logic [5:0] OFF_CTL = 6'h2A;

  localparam int DEC_SRC_LO = 14;
  localparam int DEC_BOTH   = 11;
  localparam int CTL_EN     = 3;
endpackage

// File: rtl/qep_sync.sv
module qep_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign q_o      = chain_q[STAGES-1];
  assign q_prev_o = prev_q;
endmodule

// File: rtl/qep_decode.sv
module qep_decode
  import qep_pkg::*;
(
  input  src_e       src_i,
  input  logic       both_i,
  input  logic [1:0] cur_i,   // {A,B}
  input  logic [1:0] prev_i,
  output logic       step_o,
  output logic       up_o
);
  function automatic logic [1:0] phase(input logic [1:0] ab);
    return {ab[1], ab[1] ^ ab[0]};
  endfunction

  logic [1:0] dph;
  logic       a_rise, a_chg;

  assign dph    = phase(cur_i) - phase(prev_i);
  assign a_rise = cur_i[1] & ~prev_i[1];
  assign a_chg  = cur_i[1] ^ prev_i[1];

  always_comb begin
    step_o = 1'b0;
    up_o   = 1'b1;
    unique case (src_i)
      SRC_QUAD: begin
        step_o = (dph == 2'd1) || (dph == 2'd3);  // dph==2: double flip, dropped
        up_o   = (dph == 2'd1);
      end
      SRC_PDIR: begin
        step_o = a_rise;
        up_o   = cur_i[0];
      end
      SRC_UP: begin
        step_o = both_i ? a_chg : a_rise;
        up_o   = 1'b1;
      end
      SRC_DOWN: begin
        step_o = both_i ? a_chg : a_rise;
        up_o   = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qep_pos_cnt.sv
module qep_pos_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  logic             up_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (ld_i) begin
      cnt_q <= ld_val_i;
    end else if (en_i && step_i) begin
      if (up_i) cnt_q <= (cnt_q >= max_i) ? '0 : cnt_q + 1'b1;
      else      cnt_q <= (cnt_q == '0) ? max_i : cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/qep_position_counter.sv
module qep_position_counter
  import qep_pkg::*;
#(
  parameter int               CNT_W   = 32,
  parameter int               ADDR_W  = 6,
  parameter int               SYNC_N  = 2,
  parameter logic [CNT_W-1:0] MAX_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o
);
  localparam int REG16_W = 16;
  localparam int PAD_W   = CNT_W - REG16_W;

  src_e             dec_src_q;
  logic             dec_both_q;
  logic             en_q;
  logic [CNT_W-1:0] max_q;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       ab_cur, ab_prev;
  logic             step, up, ld;
  logic [REG16_W-1:0] dec_rd, ctl_rd;

  qep_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      ({enc_a_i, enc_b_i}),
    .q_o      (ab_cur),
    .q_prev_o (ab_prev)
  );

  qep_decode u_dec (
    .src_i  (dec_src_q),
    .both_i (dec_both_q),
    .cur_i  (ab_cur),
    .prev_i (ab_prev),
    .step_o (step),
    .up_o   (up)
  );

  assign ld = wr_en_i && (addr_i == ADDR_W'(OFF_POS)) && (wdata_i <= max_q);

  qep_pos_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_q),
    .step_i   (step),
    .up_i     (up),
    .max_i    (max_q),
    .ld_i     (ld),
    .ld_val_i (wdata_i),
    .cnt_o    (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_src_q  <= SRC_QUAD;
      dec_both_q <= 1'b0;
      en_q       <= 1'b0;
      max_q      <= MAX_RST;
    end else if (wr_en_i) begin
      unique case (addr_i)
        ADDR_W'(OFF_MAX): max_q <= wdata_i;
        ADDR_W'(OFF_DEC): begin
          dec_src_q  <= src_e'(wdata_i[DEC_SRC_LO +: 2]);
          dec_both_q <= wdata_i[DEC_BOTH];
        end
        ADDR_W'(OFF_CTL): en_q <= wdata_i[CTL_EN];
        default: ;
      endcase
    end
  end

  always_comb begin
    dec_rd = '0;
    dec_rd[DEC_SRC_LO +: 2] = dec_src_q;
    dec_rd[DEC_BOTH]        = dec_both_q;
    ctl_rd = '0;
    ctl_rd[CTL_EN] = en_q;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFF_POS): rdata_o = cnt;
      ADDR_W'(OFF_MAX): rdata_o = max_q;
      ADDR_W'(OFF_DEC): rdata_o = {{PAD_W{1'b0}}, dec_rd};
      ADDR_W'(OFF_CTL): rdata_o = {{PAD_W{1'b0}}, ctl_rd};
      default:          rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/qep_position_counter_chk.sv
module qep_position_counter_chk
  import qep_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CNT_W-1:0]  wdata_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  max_i,
  input logic              en_i,
  input logic [1:0]        src_i,
  input logic [1:0]        ab_cur_i,
  input logic [1:0]        ab_prev_i
);
  logic pos_wr, load_ok, load_bad;
  assign pos_wr   = wr_en_i && (addr_i == ADDR_W'(OFF_POS));
  assign load_ok  = pos_wr && (wdata_i <= max_i);
  assign load_bad = pos_wr && (wdata_i > max_i);

  a_r7_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_ok) |=> $stable(cnt_i));

  a_r9_load_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ok |=> (cnt_i == $past(wdata_i)));

  a_r9_load_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_bad && !en_i) |=> $stable(cnt_i));

  a_r3_no_double_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_QUAD && (ab_cur_i[1] != ab_prev_i[1]) && (ab_cur_i[0] != ab_prev_i[0]) && !load_ok)
    |=> $stable(cnt_i));

  a_r4_b_only_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_PDIR && (ab_cur_i[1] == ab_prev_i[1]) && !load_ok) |=> $stable(cnt_i));

  a_r11_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ok |=> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + 1'b1 ||
                  cnt_i == $past(cnt_i) - 1'b1 || cnt_i == '0 || cnt_i == $past(max_i)));
endmodule

bind qep_position_counter qep_position_counter_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .cnt_i     (cnt),
  .max_i     (max_q),
  .en_i      (en_q),
  .src_i     (dec_src_q),
  .ab_cur_i  (ab_cur),
  .ab_prev_i (ab_prev)
);

// File: tb/tb_qep_position_counter.sv
module tb_qep_position_counter;
  localparam logic [5:0] A_POS = 6'h00, A_MAX = 6'h08, A_DEC = 6'h28, A_CTL = 6'h2A;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        a = 1'b0, b = 1'b0, wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, v;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  qep_position_counter dut (
    .clk_i(clk), .rst_ni(rst_n), .enc_a_i(a), .enc_b_i(b),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  typedef struct packed {
    logic [1:0]  src;
    logic        both;
    logic        a;
    logic        b;
    logic [3:0]  req;
    logic [31:0] exp;
  } vec_t;

  // Count starts at 100 with {A,B}=00, enabled.
  localparam vec_t VECS [27] = '{
    '{2'd0,1'b0,1'b0,1'b1,4'd2,32'd101},  // R2 up
    '{2'd0,1'b0,1'b1,1'b1,4'd2,32'd102},
    '{2'd0,1'b0,1'b1,1'b0,4'd2,32'd103},
    '{2'd0,1'b0,1'b0,1'b0,4'd2,32'd104},
    '{2'd0,1'b0,1'b1,1'b0,4'd2,32'd103},  // R2 down
    '{2'd0,1'b0,1'b1,1'b1,4'd2,32'd102},
    '{2'd0,1'b0,1'b0,1'b0,4'd3,32'd102},  // R3 double flip
    '{2'd0,1'b0,1'b1,1'b1,4'd3,32'd102},
    '{2'd0,1'b0,1'b0,1'b1,4'd2,32'd101},
    '{2'd0,1'b0,1'b0,1'b0,4'd2,32'd100},
    '{2'd1,1'b0,1'b0,1'b1,4'd4,32'd100},  // R4 B edge
    '{2'd1,1'b0,1'b1,1'b1,4'd4,32'd101},  // R4 A rise, B=1
    '{2'd1,1'b0,1'b0,1'b1,4'd4,32'd101},
    '{2'd1,1'b0,1'b0,1'b0,4'd4,32'd101},
    '{2'd1,1'b0,1'b1,1'b0,4'd4,32'd100},  // R4 A rise, B=0
    '{2'd1,1'b0,1'b0,1'b0,4'd4,32'd100},
    '{2'd2,1'b0,1'b1,1'b0,4'd5,32'd101},  // R5 rising only
    '{2'd2,1'b0,1'b1,1'b1,4'd5,32'd101},
    '{2'd2,1'b0,1'b0,1'b1,4'd5,32'd101},
    '{2'd2,1'b0,1'b0,1'b0,4'd5,32'd101},
    '{2'd2,1'b1,1'b1,1'b0,4'd5,32'd102},  // R5 both edges
    '{2'd2,1'b1,1'b0,1'b0,4'd5,32'd103},
    '{2'd3,1'b0,1'b1,1'b0,4'd6,32'd102},  // R6 rising only
    '{2'd3,1'b0,1'b0,1'b1,4'd6,32'd102},
    '{2'd3,1'b1,1'b1,1'b1,4'd6,32'd101},  // R6 both edges
    '{2'd3,1'b1,1'b0,1'b1,4'd6,32'd100},
    '{2'd3,1'b1,1'b0,1'b0,4'd6,32'd100}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] ad, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ad; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] ad, output logic [31:0] d);
    addr = ad;
    #1 d = rdata;
  endtask

  task automatic drive(input logic na, input logic nb);
    @(negedge clk);
    a = na; b = nb;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] dec_word(input logic [1:0] s, input logic bo);
    return {16'h0, s, 2'b00, bo, 11'h0};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_POS, v); check("R1 count", v, 32'h0);
    rd(A_MAX, v); check("R1 max", v, 32'hFFFF_FFFF);
    rd(A_DEC, v); check("R1 dec", v, 32'h0);
    rd(A_CTL, v); check("R1 ctl", v, 32'h0);

    wr(A_CTL, 32'h8);
    wr(A_POS, 32'd100);
    for (int i = 0; i < 27; i++) begin
      wr(A_DEC, dec_word(VECS[i].src, VECS[i].both));
      drive(VECS[i].a, VECS[i].b);
      rd(A_POS, v);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].exp);
    end

    // R7: disabled holds, load still applies
    wr(A_CTL, 32'h0);
    wr(A_DEC, dec_word(2'd2, 1'b1));
    drive(1, 0); drive(0, 0);
    rd(A_POS, v); check("R7 hold", v, 32'd100);
    wr(A_POS, 32'd60);
    rd(A_POS, v); check("R7 load while off", v, 32'd60);
    wr(A_CTL, 32'h8);

    // R9: load bounds
    wr(A_MAX, 32'd200);
    wr(A_POS, 32'd300);
    rd(A_POS, v); check("R9 over max refused", v, 32'd60);
    wr(A_POS, 32'd200);
    rd(A_POS, v); check("R9 equal max taken", v, 32'd200);

    // R8: wrap both ways
    wr(A_DEC, dec_word(2'd2, 1'b0));
    drive(1, 0);
    rd(A_POS, v); check("R8 up wrap", v, 32'd0);
    wr(A_DEC, dec_word(2'd3, 1'b0));
    drive(0, 0);
    rd(A_POS, v); check("R6 fall ignored", v, 32'd0);
    drive(1, 0);
    rd(A_POS, v); check("R8 down wrap", v, 32'd200);
    drive(0, 0); drive(1, 0);
    rd(A_POS, v); check("R6 down", v, 32'd199);

    // R11: latency of three edges
    wr(A_DEC, dec_word(2'd2, 1'b0));
    drive(0, 0);
    @(negedge clk); a = 1'b1;
    @(negedge clk);
    @(negedge clk); rd(A_POS, v); check("R11 not early", v, 32'd199);
    @(negedge clk); rd(A_POS, v); check("R11 third edge", v, 32'd200);

    // R10: field layout
    wr(A_DEC, 32'hFFFF_FFFF);
    rd(A_DEC, v); check("R10 dec fields", v, 32'h0000_C800);
    wr(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, v); check("R10 ctl fields", v, 32'h0000_0008);
    rd(A_MAX, v); check("R10 max", v, 32'd200);
    rd(6'h04, v); check("R10 unmapped", v, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule